// File: doc/BRIEF.md
# Timer Channel Byte Access Sequencer

This block sits between an 8-bit host port and one 16-bit down-counting element of a timer channel. An upstream decoder turns each host cycle into single-cycle pulses. The block turns the byte-wide host traffic into a 16-bit count register, which is handed to the counting element. It also turns the running count and the channel state back into bytes for the host to read.

The block keeps a 6-bit control field from the last control word. Its access format sits in bits [5:4]: 01 means low byte only, 10 means high byte only, and 11 means low byte then high byte. The value 00 is handled like 11. Reads pass through a 16-bit output latch, which is transparent until a count-latch request freezes it. A status-latch request captures one byte made of the OUT level, the null-count flag and the control field. Reads and writes each keep their own byte pointer.

Top module: `cnt_byte_port`

## Requirements
- R1: After reset, `cr_val` is 0, `load_rdy` is 0, nothing is latched and both byte pointers point at the low byte.
- R2: In format 01, a count write sets `cr_val` to {8'h00, byte}, and `load_rdy` is high for exactly the one cycle after the write.
- R3: In format 10, a count write sets `cr_val` to {byte, 8'h00} and pulses `load_rdy` in the same way.
- R4: In format 11, the first write fills `cr_val[7:0]` without raising `load_rdy`. The second write fills `cr_val[15:8]` and pulses `load_rdy`.
- R5: With nothing latched, a read returns a byte of `live_cnt`: the low byte in format 01, the high byte in format 10, and low then high on alternate reads in format 11.
- R6: A count-latch request freezes the read value at the `live_cnt` of that cycle. It stays frozen until every byte the format needs has been read, and reads then follow `live_cnt` again.
- R7: A count-latch or status-latch request that arrives while an earlier value of the same kind is still unread has no effect.
- R8: The latched status byte is {OUT level, null-count, control[5:0]}, taken in the cycle of the request.
- R9: When status and count are both latched, the next read returns status whatever order they were latched in, and the following reads return the count.
- R10: Null-count is set by a control write and by the write that completes a count. It is not set by the first byte of a two-byte write. It is cleared by `ce_loaded`.
- R11: The read pointer and the write pointer are separate, so the low/high reads and writes of one count may be interleaved without corrupting either.
- R12: A control write returns both pointers to the low byte and drops any pending count or status latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control word write to this channel (`wdata[5:0]` stored) |
| cnt_wr | input | 1 | Count byte write |
| cnt_rd | input | 1 | Read strobe; advances the read state at the clock edge |
| lat_cnt | input | 1 | Count-latch request |
| lat_sts | input | 1 | Status-latch request |
| wdata | input | 8 | Host write data |
| live_cnt | input | 16 | Current value of the counting element |
| out_lvl | input | 1 | Current OUT level of the channel |
| ce_loaded | input | 1 | Count register was transferred into the counting element |
| rdata | output | 8 | Read byte, valid while `cnt_rd` is high |
| load_rdy | output | 1 | One-cycle pulse when a full count has been written |
| cr_val | output | 16 | Count register value for the counting element |

## Verification
The bench keeps changing `live_cnt` after a count latch. A latch that did not freeze, or that released after the low byte only, would then return the later value. It issues repeated latch requests before reading, which would expose a design that re-captured on the second request. It latches count before status, so a design that read the latches in arrival order would return the count byte where status is expected. It interleaves writes with reads of one two-byte count and issues a control write mid-sequence. A shared pointer, or a stale pointer left after the control write, would then misplace bytes or raise `load_rdy` after one byte.

// File: rtl/cnt_byte_port.sv
module cnt_byte_port #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_wr,
  input  logic          cnt_wr,
  input  logic          cnt_rd,
  input  logic          lat_cnt,
  input  logic          lat_sts,
  input  logic [DW-1:0] wdata,
  input  logic [2*DW-1:0] live_cnt,
  input  logic          out_lvl,
  input  logic          ce_loaded,
  output logic [DW-1:0] rdata,
  output logic          load_rdy,
  output logic [2*DW-1:0] cr_val
);
  localparam int CW = 2 * DW;

  logic [5:0]    ctrl_q;
  logic [CW-1:0] cr_q, ol_q;
  logic [DW-1:0] sts_q;
  logic          null_q, wr_hi, rd_hi, ol_frz, sts_hld, load_q;

  wire [1:0]    fmt     = ctrl_q[5:4];
  wire          two_b   = ~(fmt[1] ^ fmt[0]);
  wire          wr_last = cnt_wr && !ctl_wr && (!two_b || wr_hi);
  wire [CW-1:0] rd_src  = ol_frz ? ol_q : live_cnt;
  wire          hi_sel  = (fmt == 2'b10) || (two_b && rd_hi);

  assign rdata    = sts_hld ? sts_q : (hi_sel ? rd_src[CW-1:DW] : rd_src[DW-1:0]);
  assign load_rdy = load_q;
  assign cr_val   = cr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      cr_q    <= '0;
      ol_q    <= '0;
      sts_q   <= '0;
      null_q  <= 1'b0;
      wr_hi   <= 1'b0;
      rd_hi   <= 1'b0;
      ol_frz  <= 1'b0;
      sts_hld <= 1'b0;
      load_q  <= 1'b0;
    end else begin
      load_q <= wr_last;
      if (ctl_wr) begin
        ctrl_q  <= wdata[5:0];
        wr_hi   <= 1'b0;
        rd_hi   <= 1'b0;
        ol_frz  <= 1'b0;
        sts_hld <= 1'b0;
        null_q  <= 1'b1;
      end else begin
        if (cnt_wr) begin
          case (fmt)
            2'b01:   cr_q <= {{DW{1'b0}}, wdata};
            2'b10:   cr_q <= {wdata, {DW{1'b0}}};
            default: begin
              if (wr_hi) cr_q[CW-1:DW] <= wdata;
              else       cr_q[DW-1:0]  <= wdata;
              wr_hi <= !wr_hi;
            end
          endcase
        end
        if (wr_last)        null_q <= 1'b1;
        else if (ce_loaded) null_q <= 1'b0;

        if (cnt_rd) begin
          if (sts_hld)             sts_hld <= 1'b0;
          else if (two_b && !rd_hi) rd_hi  <= 1'b1;
          else begin
            rd_hi  <= 1'b0;
            ol_frz <= 1'b0;
          end
        end
        if (lat_cnt && !ol_frz) begin
          ol_q   <= live_cnt;
          ol_frz <= 1'b1;
        end
        if (lat_sts && !sts_hld) begin
          sts_q   <= {out_lvl, null_q, ctrl_q};
          sts_hld <= 1'b1;
        end
      end
    end
  end

  // R2
  load_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_rdy |-> $past(cnt_wr));
  // R4
  two_byte_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr && two_b && !wr_hi && !ctl_wr) |=> !load_rdy);
  // R6
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ol_frz && !sts_hld && !cnt_rd && !ctl_wr && !lat_sts) |=> $stable(rdata));
  // R12
  ctl_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (!ol_frz && !sts_hld && !wr_hi && !rd_hi && null_q));
  // R10
  null_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_loaded && !cnt_wr && !ctl_wr) |=> !null_q);
endmodule

// File: tb/cnt_byte_port_tb.sv
`timescale 1ns/1ps
module cnt_byte_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_wr = 0, cnt_wr = 0, cnt_rd = 0, lat_cnt = 0, lat_sts = 0;
  logic [7:0]  wdata = '0;
  logic [15:0] live_cnt = '0;
  logic        out_lvl = 0, ce_loaded = 0;
  logic [7:0]  rdata;
  logic        load_rdy;
  logic [15:0] cr_val;

  int n_chk = 0, n_bad = 0;

  typedef struct { logic [7:0] v; string tag; } exp_t;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  cnt_byte_port u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .cnt_wr(cnt_wr), .cnt_rd(cnt_rd),
    .lat_cnt(lat_cnt), .lat_sts(lat_sts), .wdata(wdata), .live_cnt(live_cnt),
    .out_lvl(out_lvl), .ce_loaded(ce_loaded), .rdata(rdata), .load_rdy(load_rdy),
    .cr_val(cr_val)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && cnt_rd) begin
      if (exp_q.size() == 0) chk("read without expectation", 16'(rdata), 16'hxxxx);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(e.tag, 16'(rdata), 16'(e.v));
      end
    end
  end

  task automatic tick;
    @(posedge clk); #1;
  endtask
  task automatic ctl(input logic [7:0] b);
    ctl_wr = 1; wdata = b; tick(); ctl_wr = 0;
  endtask
  task automatic wr(input logic [7:0] b);
    cnt_wr = 1; wdata = b; tick(); cnt_wr = 0;
  endtask
  task automatic rd(input logic [7:0] e, input string tag);
    exp_t x;
    x.v = e; x.tag = tag;
    exp_q.push_back(x);
    cnt_rd = 1; tick(); cnt_rd = 0;
  endtask
  task automatic lc;
    lat_cnt = 1; tick(); lat_cnt = 0;
  endtask
  task automatic ls;
    lat_sts = 1; tick(); lat_sts = 0;
  endtask
  task automatic ld;
    ce_loaded = 1; tick(); ce_loaded = 0;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1; tick();
    chk("R1 cr_val after reset", cr_val, 16'h0000);
    chk("R1 load_rdy after reset", 16'(load_rdy), 16'h0);

    // format 01
    ctl(8'h14);
    wr(8'hA5);
    chk("R2 cr_val low only", cr_val, 16'h00A5);
    chk("R2 load_rdy pulse", 16'(load_rdy), 16'h1);
    tick();
    chk("R2 load_rdy one cycle", 16'(load_rdy), 16'h0);
    live_cnt = 16'h1234;
    rd(8'h34, "R5 low byte format 01");

    // format 10
    ctl(8'h26);
    wr(8'h7E);
    chk("R3 cr_val high only", cr_val, 16'h7E00);
    chk("R3 load_rdy pulse", 16'(load_rdy), 16'h1);
    rd(8'h12, "R5 high byte format 10");

    // format 11
    ctl(8'h30);
    wr(8'h11);
    chk("R4 no load after first byte", 16'(load_rdy), 16'h0);
    wr(8'h22);
    chk("R4 cr_val two bytes", cr_val, 16'h2211);
    chk("R4 load after second byte", 16'(load_rdy), 16'h1);
    live_cnt = 16'hBEEF;
    rd(8'hEF, "R5 two-byte read low");
    rd(8'hBE, "R5 two-byte read high");

    // count latch
    live_cnt = 16'h4321; lc();
    live_cnt = 16'h9999; lc();
    live_cnt = 16'h5555;
    rd(8'h21, "R6 R7 latched low byte");
    live_cnt = 16'h7788;
    rd(8'h43, "R6 R7 latched high byte");
    rd(8'h88, "R6 follows live after full read");
    rd(8'h77, "R6 follows live high");

    // status latch and priority
    out_lvl = 1; ld();
    live_cnt = 16'hABCD; lc();
    live_cnt = 16'h0000;
    ls();
    out_lvl = 0; ls();
    rd(8'hB0, "R8 R9 R7 status first");
    rd(8'hCD, "R9 count low after status");
    rd(8'hAB, "R9 count high after status");

    // null count
    ctl(8'h30); ls();
    rd(8'h70, "R10 null set by control write");
    ld(); wr(8'h01); ls();
    rd(8'h30, "R10 first byte leaves null clear");
    wr(8'h02); ls();
    rd(8'h70, "R10 null set by second byte");
    chk("R10 cr_val", cr_val, 16'h0201);

    // interleaved pointers
    live_cnt = 16'h1357; lc();
    rd(8'h57, "R11 interleaved read low");
    wr(8'hAA);
    live_cnt = 16'h0000;
    rd(8'h13, "R11 interleaved read high");
    wr(8'hBB);
    chk("R11 interleaved cr_val", cr_val, 16'hBBAA);
    chk("R11 interleaved load", 16'(load_rdy), 16'h1);

    // control write resets
    wr(8'h44);
    live_cnt = 16'h2468; lc();
    rd(8'h68, "R12 setup read");
    ls();
    ctl(8'h30);
    live_cnt = 16'h1A2B;
    rd(8'h2B, "R12 latches dropped, pointer low");
    wr(8'h55);
    chk("R12 write pointer low after control", 16'(load_rdy), 16'h0);
    wr(8'h66);
    chk("R12 cr_val after control", cr_val, 16'h6655);
    chk("R12 load after second byte", 16'(load_rdy), 16'h1);

    repeat (3) tick();
    chk("scoreboard drained", 16'(exp_q.size()), 16'h0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule